// File: doc/BRIEF.md
# Noise-Shaped Phase Error Dither

This block sits in the phase-error path of an all-digital PLL, between the time-to-digital converter and the loop filter. It adds a small pseudo-random offset to each phase-error sample. The offset keeps the quantized error moving across several converter steps. This stops a locked integer-N loop from resting inside one flat quantizer step, where the loop gain collapses and the phase drifts with the loop effectively open.

The random source is a 23-bit maximal-length shift register. Its output bit drives one of two offset generators. The flat generator gives a symmetric +/-1 per sample. The shaped generator applies the third-order difference (1 - z^-1)^3 to the random bit stream. That pushes the offset energy to high frequencies, outside the loop bandwidth, and its running sum stays bounded, so the long-term mean is zero and the loop locks without a static phase offset. A 3-bit code sets the offset size as a left shift. The offset is then added with saturation to a 16-bit signed error word that has 8 fractional bits.

The state advances once per reference cycle, on the input valid strobe. When the block is disabled, it reloads its seed, clears its shaping history, and passes samples through with the same one-cycle latency.

Top module: `nsd_dither`

## Requirements
- R1: After reset, `pe_out` is 0 and `pe_out_valid` is 0.
- R2: `pe_out_valid` is high in exactly the cycle after a cycle in which `pe_valid` is high.
- R3: While `enable` is low, a valid sample appears unchanged on `pe_out` one cycle later, whatever the values of `mode` and `amp`.
- R4: While `enable` is high and `mode` is 0 or 3 (off), a valid sample passes through unchanged.
- R5: The random bit for each step is b = s[22] XOR s[17] of the current 23-bit state s. The new state is {s[21:0], b}. The state is loaded from `seed` during reset and in every cycle in which `enable` is low.
- R6: A seed of zero is replaced by the state value 23'h000001.
- R7: With `mode` = 1 (flat), the offset is (+1 if b = 1, else -1) shifted left by `amp`.
- R8: With `mode` = 2 (shaped), the offset is (b[n] - 3*b[n-1] + 3*b[n-2] - b[n-3]) shifted left by `amp`. The history of b is cleared while `enable` is low.
- R9: In shaped mode with `amp` = 0, the running sum of the offsets since enable was raised always lies in [-2, 2].
- R10: The sum of sample and offset saturates to 32767 or -32768 and never wraps.
- R11: The random state and the shaping history advance only on cycles with `pe_valid` high while `enable` is high.
- R12: `pe_out` holds its value in any cycle that follows a cycle without `pe_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Dither enable; low reloads seed, clears history, bypasses |
| mode | input | 2 | 0/3 off, 1 flat random, 2 noise-shaped |
| amp | input | 3 | Offset left-shift amount |
| seed | input | 23 | Shift-register seed |
| pe_valid | input | 1 | One strobe per reference cycle |
| pe_in | input | 16 | Signed phase error, 8 fractional bits |
| pe_out | output | 16 | Dithered signed phase error |
| pe_out_valid | output | 1 | Output strobe, one cycle after `pe_valid` |

## Verification
A corrupted shift-register tap or a stuck state shows up in the first flat-mode samples as a sign sequence that departs from the polynomial. A zero seed that is not replaced shows up within 18 samples, because the expected first +1 never appears. A wrong history coefficient or a history that is not cleared breaks the [-2, 2] bound on the running sum of shaped offsets within a few samples, and it changes individual output values at once. Saturation faults appear on the first sample near full scale that has an offset pointing outward.

// File: rtl/nsd_pkg.sv
package nsd_pkg;
    typedef enum logic [1:0] {
        DM_OFF     = 2'd0,
        DM_FLAT    = 2'd1,
        DM_SHAPED  = 2'd2,
        DM_OFF_ALT = 2'd3
    } dmode_e;

    // width of the unscaled signed offset (-4..+4)
    localparam int RAW_W = 4;
    // shaping order (fixed third-order difference)
    localparam int HIST_N = 3;
endpackage

// File: rtl/nsd_lfsr.sv
module nsd_lfsr #(
    parameter int           W        = 23,
    parameter int           TAP_HI   = 22,
    parameter int           TAP_LO   = 17,
    parameter logic [W-1:0] FALLBACK = {{(W-1){1'b0}}, 1'b1}
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] seed,
    output logic         bit_o
);
    typedef struct packed {
        logic [W-1:0] st;
    } lfsr_s;

    lfsr_s        r_d, r_q;
    logic [W-1:0] seed_fix;
    logic         nb;

    always_comb begin
        seed_fix = (seed == '0) ? FALLBACK : seed;
        nb       = r_q.st[TAP_HI] ^ r_q.st[TAP_LO];
        bit_o    = nb;
        r_d      = r_q;
        if (!rst_n || load) begin
            r_d.st = seed_fix;
        end else if (step) begin
            r_d.st = {r_q.st[W-2:0], nb};
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end
endmodule

// File: rtl/nsd_shaper.sv
module nsd_shaper
    import nsd_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    step,
    input  logic                    bit_i,
    input  dmode_e                  mode,
    output logic signed [RAW_W-1:0] raw_shaped,
    output logic signed [RAW_W-1:0] raw_sel
);
    typedef struct packed {
        logic [HIST_N-1:0] h;   // h[0] = b[n-1], h[1] = b[n-2], h[2] = b[n-3]
    } shp_s;

    shp_s                    s_d, s_q;
    logic signed [RAW_W-1:0] raw_flat;
    int                      acc;

    always_comb begin
        acc = int'(bit_i)
            - 3 * int'(s_q.h[0])
            + 3 * int'(s_q.h[1])
            - int'(s_q.h[2]);
        raw_shaped = acc[RAW_W-1:0];
        raw_flat   = bit_i ? RAW_W'(1) : {RAW_W{1'b1}};

        case (mode)
            DM_FLAT:   raw_sel = raw_flat;
            DM_SHAPED: raw_sel = raw_shaped;
            default:   raw_sel = '0;
        endcase

        s_d = s_q;
        if (!rst_n || clear) begin
            s_d.h = '0;
        end else if (step) begin
            s_d.h = {s_q.h[HIST_N-2:0], bit_i};
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end
endmodule

// File: rtl/nsd_scale_sat.sv
module nsd_scale_sat #(
    parameter int PE_W  = 16,
    parameter int RAW_W = 4,
    parameter int AMP_W = 3,
    parameter int SC_W  = RAW_W + (1 << AMP_W) - 1
) (
    input  logic signed [PE_W-1:0]  pe,
    input  logic signed [RAW_W-1:0] raw,
    input  logic        [AMP_W-1:0] amp,
    output logic signed [SC_W-1:0]  ofs_scaled,
    output logic signed [PE_W-1:0]  sum_sat
);
    localparam int SUM_W = PE_W + 1;

    logic signed [SC_W-1:0]  raw_ext;
    logic signed [SUM_W-1:0] sum;

    always_comb begin
        raw_ext    = {{(SC_W-RAW_W){raw[RAW_W-1]}}, raw};
        ofs_scaled = raw_ext <<< amp;
        sum        = {pe[PE_W-1], pe}
                   + {{(SUM_W-SC_W){ofs_scaled[SC_W-1]}}, ofs_scaled};
        if (sum[SUM_W-1] != sum[PE_W-1]) begin
            sum_sat = sum[SUM_W-1] ? {1'b1, {(PE_W-1){1'b0}}}
                                   : {1'b0, {(PE_W-1){1'b1}}};
        end else begin
            sum_sat = sum[PE_W-1:0];
        end
    end
endmodule

// File: rtl/nsd_dither.sv
module nsd_dither
    import nsd_pkg::*;
#(
    parameter int                PE_W          = 16,
    parameter int                LFSR_W        = 23,
    parameter int                AMP_W         = 3,
    parameter logic [LFSR_W-1:0] SEED_FALLBACK = {{(LFSR_W-1){1'b0}}, 1'b1}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [1:0]        mode,
    input  logic [AMP_W-1:0]  amp,
    input  logic [LFSR_W-1:0] seed,
    input  logic              pe_valid,
    input  logic [PE_W-1:0]   pe_in,
    output logic [PE_W-1:0]   pe_out,
    output logic              pe_out_valid
);
    localparam int SC_W = RAW_W + (1 << AMP_W) - 1;

    typedef struct packed {
        logic [PE_W-1:0] pe;
        logic            vld;
    } out_s;

    out_s                    o_d, o_q;
    logic                    step;
    logic                    rbit;
    dmode_e                  dmode;
    logic signed [RAW_W-1:0] raw_shaped;
    logic signed [RAW_W-1:0] raw_sel;
    logic signed [SC_W-1:0]  ofs_scaled;
    logic signed [PE_W-1:0]  sum_sat;

    assign step  = enable & pe_valid;
    assign dmode = dmode_e'(mode);

    nsd_lfsr #(
        .W        (LFSR_W),
        .TAP_HI   (LFSR_W - 1),
        .TAP_LO   (LFSR_W - 6),
        .FALLBACK (SEED_FALLBACK)
    ) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (!enable),
        .step  (step),
        .seed  (seed),
        .bit_o (rbit)
    );

    nsd_shaper u_shaper (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (!enable),
        .step       (step),
        .bit_i      (rbit),
        .mode       (dmode),
        .raw_shaped (raw_shaped),
        .raw_sel    (raw_sel)
    );

    nsd_scale_sat #(
        .PE_W  (PE_W),
        .RAW_W (RAW_W),
        .AMP_W (AMP_W),
        .SC_W  (SC_W)
    ) u_sat (
        .pe         (pe_in),
        .raw        (raw_sel),
        .amp        (amp),
        .ofs_scaled (ofs_scaled),
        .sum_sat    (sum_sat)
    );

    always_comb begin
        o_d     = o_q;
        o_d.vld = pe_valid;
        if (!rst_n) begin
            o_d = '0;
        end else if (pe_valid) begin
            o_d.pe = enable ? sum_sat : pe_in;
        end
    end

    always_ff @(posedge clk) begin
        o_q <= o_d;
    end

    assign pe_out       = o_q.pe;
    assign pe_out_valid = o_q.vld;
endmodule

// File: rtl/nsd_dither_chk.sv
module nsd_dither_chk #(
    parameter int PE_W  = 16,
    parameter int RAW_W = 4,
    parameter int SC_W  = 11
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    enable,
    input logic                    pe_valid,
    input logic [PE_W-1:0]         pe_in,
    input logic [PE_W-1:0]         pe_out,
    input logic                    pe_out_valid,
    input logic signed [RAW_W-1:0] raw_shaped,
    input logic signed [SC_W-1:0]  ofs_scaled
);
    logic signed [7:0] psum;

    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            psum <= '0;
        end else if (pe_valid) begin
            psum <= psum + 8'(raw_shaped);
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!pe_out_valid && pe_out == '0));

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pe_valid |=> pe_out_valid);

    // R2
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pe_valid |=> !pe_out_valid);

    // R3
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && pe_valid) |=> (pe_out == $past(pe_in)));

    // R9
    zero_mean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psum >= -8'sd2) && (psum <= 8'sd2));

    // R10
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && pe_valid && !pe_in[PE_W-1] && !ofs_scaled[SC_W-1])
        |=> !pe_out[PE_W-1]);

    // R12
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pe_valid |=> $stable(pe_out));
endmodule

bind nsd_dither nsd_dither_chk #(
    .PE_W  (PE_W),
    .RAW_W (nsd_pkg::RAW_W),
    .SC_W  (SC_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .pe_valid     (pe_valid),
    .pe_in        (pe_in),
    .pe_out       (pe_out),
    .pe_out_valid (pe_out_valid),
    .raw_shaped   (raw_shaped),
    .ofs_scaled   (ofs_scaled)
);

// File: tb/nsd_dither_test.sv
module nsd_dither_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [2:0]  amp = 3'd0;
    logic [22:0] seed = 23'h2A5F13;
    logic        pe_valid = 1'b0;
    logic [15:0] pe_in = 16'h0;
    logic [15:0] pe_out;
    logic        pe_out_valid;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    // reference model state
    logic [22:0] m_st;
    logic [2:0]  m_h;
    logic [15:0] exp_out;
    string       tag_ovr = "";

    always #4 clk = ~clk;

    nsd_dither uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .mode         (mode),
        .amp          (amp),
        .seed         (seed),
        .pe_valid     (pe_valid),
        .pe_in        (pe_in),
        .pe_out       (pe_out),
        .pe_out_valid (pe_out_valid)
    );

    typedef struct packed {
        logic        en;
        logic [1:0]  md;
        logic [2:0]  a;
        logic [15:0] pe;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 3'd0, 16'h0123},
        '{1'b0, 2'd2, 3'd5, 16'hFF00},
        '{1'b1, 2'd0, 3'd4, 16'h1234},
        '{1'b1, 2'd3, 3'd7, 16'h8001},
        '{1'b1, 2'd1, 3'd0, 16'h0000},
        '{1'b1, 2'd1, 3'd3, 16'h0100},
        '{1'b1, 2'd1, 3'd7, 16'hFE00},
        '{1'b1, 2'd2, 3'd0, 16'h0000},
        '{1'b1, 2'd2, 3'd2, 16'h0040},
        '{1'b1, 2'd2, 3'd6, 16'hFFC0},
        '{1'b1, 2'd2, 3'd7, 16'h7FFF},
        '{1'b1, 2'd2, 3'd7, 16'h8000},
        '{1'b1, 2'd2, 3'd7, 16'h7F00},
        '{1'b1, 2'd2, 3'd1, 16'h8010},
        '{1'b0, 2'd2, 3'd1, 16'h4444},
        '{1'b1, 2'd2, 3'd0, 16'h0000}
    };

    function automatic logic [22:0] fix_seed(input logic [22:0] s);
        return (s == 23'h0) ? 23'h000001 : s;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic apply(input logic en, input logic [1:0] md, input logic [2:0] a,
                         input logic [15:0] pe, input logic v);
        int    rawv;
        int    s;
        logic  nb;
        string tg;
        enable   = en;
        mode     = md;
        amp      = a;
        pe_in    = pe;
        pe_valid = v;
        tg = !en ? "R3" : ((md == 2'd0 || md == 2'd3) ? "R4" : (md == 2'd1 ? "R7" : "R8"));
        if (!en) begin
            m_st = fix_seed(seed);
            m_h  = 3'b000;
            if (v) exp_out = pe;
        end else if (v) begin
            nb = m_st[22] ^ m_st[17];
            case (md)
                2'd1:    rawv = nb ? 1 : -1;
                2'd2:    rawv = int'(nb) - 3 * int'(m_h[0]) + 3 * int'(m_h[1]) - int'(m_h[2]);
                default: rawv = 0;
            endcase
            s = int'($signed(pe)) + rawv * (1 << a);
            if (s > 32767) begin s = 32767; tg = "R10"; end
            if (s < -32768) begin s = -32768; tg = "R10"; end
            exp_out = s[15:0];
            m_st = {m_st[21:0], nb};
            m_h  = {m_h[1:0], nb};
        end
        if (!v) tg = "R12";
        if (tag_ovr != "") tg = tag_ovr;
        @(posedge clk);
        @(negedge clk);
        check("R2", {15'h0, pe_out_valid}, {15'h0, v});
        check(tg, pe_out, exp_out);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int sum;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", pe_out, 16'h0);
        check("R1", {15'h0, pe_out_valid}, 16'h0);
        rst_n   = 1'b1;
        m_st    = fix_seed(seed);
        m_h     = 3'b000;
        exp_out = 16'h0;

        // table walk
        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].en, VECS[i].md, VECS[i].a, VECS[i].pe, 1'b1);
        end

        // R11: gaps without valid do not advance the sequence
        tag_ovr = "R11";
        for (int i = 0; i < 12; i++) begin
            apply(1'b1, 2'd2, 3'd3, 16'h0200, 1'b1);
            if (i % 3 == 0) begin
                tag_ovr = "R12";
                apply(1'b1, 2'd2, 3'd3, 16'h0555, 1'b0);
                apply(1'b1, 2'd1, 3'd5, 16'h0777, 1'b0);
                tag_ovr = "R11";
            end
        end
        tag_ovr = "";

        // R5: polynomial and seed load
        seed = 23'h400000;
        apply(1'b0, 2'd1, 3'd0, 16'h0000, 1'b1);
        apply(1'b1, 2'd1, 3'd0, 16'h0000, 1'b1);
        check("R5", pe_out, 16'h0001);
        apply(1'b1, 2'd1, 3'd0, 16'h0000, 1'b1);
        check("R5", pe_out, 16'hFFFF);

        // R6: zero seed replaced by 1; first +1 appears on the 18th step
        seed = 23'h0;
        apply(1'b0, 2'd1, 3'd0, 16'h0000, 1'b1);
        for (int i = 1; i <= 18; i++) begin
            apply(1'b1, 2'd1, 3'd0, 16'h0000, 1'b1);
            if (i == 1)  check("R6", pe_out, 16'hFFFF);
            if (i == 18) check("R6", pe_out, 16'h0001);
        end

        // R9: shaped running sum bounded
        seed = 23'h13579B;
        apply(1'b0, 2'd2, 3'd0, 16'h0000, 1'b1);
        sum = 0;
        for (int i = 0; i < 150; i++) begin
            apply(1'b1, 2'd2, 3'd0, 16'h0000, 1'b1);
            sum += int'($signed(pe_out));
            checks++;
            if (sum > 2 || sum < -2) begin
                fails++;
                $display("FAIL R9 actual=%0d expected=within[-2,2]", sum);
            end
        end

        // R10: saturation at both rails with largest shift
        for (int i = 0; i < 20; i++) begin
            apply(1'b1, 2'd2, 3'd7, (i % 2 == 0) ? 16'h7FF0 : 16'h8008, 1'b1);
        end

        // R1 again: reset mid-run
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1", pe_out, 16'h0);
        check("R1", {15'h0, pe_out_valid}, 16'h0);

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule